// File: doc/BRIEF.md
# Teletext Buffer Fetch Controller

This block feeds a serial teletext stream to an external video encoder from data held in system memory. It holds a 64-byte FIFO, built as 16 words of 32 bits. It refills that FIFO in fixed blocks of 46 bytes, which is one teletext data unit. Each block is read as twelve 32-bit words. The two bytes that trail the last word are dropped. Blocks follow one another in memory at a 48-byte stride, beginning at a programmable start address.

The encoder pulls data over two wires. A request line comes in and a data line goes out. While request is high the block shifts out one bit per clock, most significant bit first, and takes a new byte from the FIFO at each byte boundary. A refill starts only when the FIFO has at least 48 free bytes. This guarantees that a whole data unit always fits.

Dropping the enable input empties the FIFO, abandons any fetch in progress, clears the underrun flag and reloads the fetch address from the start-address input.

Top module: `ttx_fetch_ctrl`

## Requirements
- R1: After reset, `mem_req_o`, `txd_o` and `underrun_o` are all 0.
- R2: A block fetch begins only when the FIFO holds at most 16 bytes, meaning at least 48 bytes are free. With 17 or more bytes held, no fetch starts.
- R3: A block is exactly 12 granted word reads. Word addresses rise by 4 from the start address, so block k starts at start + 48·k. The two low bits of the start address are treated as zero.
- R4: The serial stream carries bytes 0 to 45 of each block in address order. Byte a of a word is `mem_rdata_i[8a+7:8a]`, and bytes 46 and 47 of each block are never sent.
- R5: Each clock edge with `txd_req_i` high moves one bit onto `txd_o`, MSB first. After an edge with `txd_req_i` low, `txd_o` is 0.
- R6: If a byte boundary is reached with `txd_req_i` high and the FIFO empty, `underrun_o` becomes 1 and `txd_o` is 0. The flag stays set until enable is dropped.
- R7: While `en_i` is 0 the FIFO is emptied, `underrun_o` is cleared, no fetch is requested, and the fetch address is reloaded from `start_addr_i`.
- R8: While `mem_req_o` is high and `mem_gnt_i` is low, the request and its address are held unchanged.
- R9: The FIFO never accepts more bytes than it has free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low flushes and reloads the address |
| start_addr_i | input | 32 | Byte address of the first block |
| mem_req_o | output | 1 | Word read request |
| mem_addr_o | output | 32 | Word-aligned byte address of the read |
| mem_gnt_i | input | 1 | Grant; read data is valid in the same cycle |
| mem_rdata_i | input | 32 | Read data, lowest address in bits 7:0 |
| txd_req_i | input | 1 | Request line from the encoder |
| txd_o | output | 1 | Serial data line |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
Every memory byte is a fixed arithmetic function of its address. The whole serial stream can therefore be rebuilt in the bench and compared byte by byte across several consecutive blocks. This comparison shows whether the trailing bytes are dropped, the lanes are in the right order and the stride is correct. The stream is run once with grant always given and once with grant given only every third cycle, which separates correct request holding from address skipping or duplication. The refill threshold is probed by draining exactly 29 bytes and then 30 bytes, one byte either side of the trigger point. A disable with grant withheld must produce an immediate underrun, which shows the flush. A restart at a new address shows the address reload.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic [0:0] {FS_IDLE, FS_FETCH} fetch_state_e;
endpackage

// File: rtl/ttx_fifo.sv
module ttx_fifo #(
  parameter int unsigned BYTES      = 64,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned CNT_W      = $clog2(BYTES + 1),
  parameter int unsigned PTR_W      = $clog2(BYTES),
  parameter int unsigned LANE_W     = $clog2(WORD_BYTES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    push_i,
  input  logic [LANE_W-1:0]       push_n_i,
  input  logic [WORD_BYTES*8-1:0] push_data_i,
  input  logic                    pop_i,
  output logic [7:0]              pop_data_o,
  output logic [CNT_W-1:0]        count_o,
  output logic                    empty_o
);
  // byte-addressed ring; BYTES must be a power of two so pointers wrap
  logic [7:0]       mem_q [BYTES];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) begin
      for (int l = 0; l < WORD_BYTES; l++) begin
        if (LANE_W'(l) < push_n_i) mem_q[wptr_q + PTR_W'(l)] <= push_data_i[l*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_q + PTR_W'(push_n_i);
      if (pop_i)  rptr_q <= rptr_q + PTR_W'(1);
      count_q <= count_q + (push_i ? CNT_W'(push_n_i) : CNT_W'(0)) - CNT_W'(pop_i);
    end
  end

  assign pop_data_o = mem_q[rptr_q];
  assign count_o    = count_q;
  assign empty_o    = (count_q == '0);

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i) |-> (int'(count_q) + int'(push_n_i) <= int'(BYTES)));
  assert_no_pop_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/ttx_fetch.sv
module ttx_fetch
  import ttx_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned WORD_BYTES  = 4,
  parameter int unsigned UNIT_WORDS  = 12,
  parameter int unsigned LAST_BYTES  = 2,
  parameter int unsigned FIFO_BYTES  = 64,
  parameter int unsigned REFILL_FREE = 48,
  parameter int unsigned CNT_W       = 7,
  parameter int unsigned LANE_W      = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [ADDR_W-1:0]       start_addr_i,
  input  logic [CNT_W-1:0]        fifo_count_i,
  output logic                    mem_req_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  input  logic                    mem_gnt_i,
  input  logic [WORD_BYTES*8-1:0] mem_rdata_i,
  output logic                    push_o,
  output logic [LANE_W-1:0]       push_n_o,
  output logic [WORD_BYTES*8-1:0] push_data_o
);
  localparam int unsigned WCNT_W = $clog2(UNIT_WORDS + 1);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(WORD_BYTES - 1);

  fetch_state_e      st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WCNT_W-1:0] wcnt_q;
  logic              can_start, last_word;

  assign can_start = int'(fifo_count_i) <= int'(FIFO_BYTES - REFILL_FREE);
  assign last_word = (wcnt_q == WCNT_W'(UNIT_WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FS_IDLE;
      addr_q <= '0;
      wcnt_q <= '0;
    end else if (!en_i) begin
      st_q   <= FS_IDLE;
      addr_q <= start_addr_i & ALIGN_MASK;
      wcnt_q <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: if (can_start) begin
          st_q   <= FS_FETCH;
          wcnt_q <= '0;
        end
        FS_FETCH: if (mem_gnt_i) begin
          addr_q <= addr_q + ADDR_W'(WORD_BYTES);
          if (last_word) begin
            st_q   <= FS_IDLE;
            wcnt_q <= '0;
          end else begin
            wcnt_q <= wcnt_q + WCNT_W'(1);
          end
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (st_q == FS_FETCH) && en_i;
  assign mem_addr_o  = addr_q;
  assign push_o      = mem_req_o && mem_gnt_i;
  assign push_n_o    = last_word ? LANE_W'(LAST_BYTES) : LANE_W'(WORD_BYTES);
  assign push_data_o = mem_rdata_i;

  assert_start_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> (int'(fifo_count_i) <= int'(FIFO_BYTES - REFILL_FREE)));
  assert_addr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> $stable(mem_addr_o));
  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i && en_i) |=> (mem_req_o || !en_i));
endmodule

// File: rtl/ttx_serial.sv
module ttx_serial
  import ttx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              req_i,
  input  logic              empty_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              pop_o,
  output logic              data_o,
  output logic              underrun_o
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);

  logic [IDX_W-1:0]  bidx_q;
  logic [BYTE_W-2:0] sh_q;
  logic              data_q, unr_q, boundary;

  assign boundary = en_i && req_i && (bidx_q == '0);
  assign pop_o    = boundary && !empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bidx_q <= '0;
      sh_q   <= '0;
      data_q <= 1'b0;
      unr_q  <= 1'b0;
    end else if (!en_i) begin
      bidx_q <= '0;
      data_q <= 1'b0;
      unr_q  <= 1'b0;
    end else if (req_i) begin
      if (bidx_q == '0) begin
        if (!empty_i) begin
          data_q <= byte_i[BYTE_W-1];
          sh_q   <= byte_i[BYTE_W-2:0];
          bidx_q <= IDX_W'(1);
        end else begin
          data_q <= 1'b0;   // hold line low and retry next clock
          unr_q  <= 1'b1;
        end
      end else begin
        data_q <= sh_q[BYTE_W-2];
        sh_q   <= {sh_q[BYTE_W-3:0], 1'b0};
        bidx_q <= bidx_q + IDX_W'(1);
      end
    end else begin
      data_q <= 1'b0;
    end
  end

  assign data_o     = data_q;
  assign underrun_o = unr_q;

  assert_idle_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !data_o);
  assert_underrun_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && en_i) |=> underrun_o);
  assert_underrun_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary && empty_i) |=> (!data_o && underrun_o));
endmodule

// File: rtl/ttx_fetch_ctrl.sv
module ttx_fetch_ctrl
  import ttx_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned FIFO_WORDS  = 16,
  parameter int unsigned WORD_BYTES  = 4,
  parameter int unsigned UNIT_BYTES  = 46,
  parameter int unsigned REFILL_FREE = 48
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [ADDR_W-1:0]       start_addr_i,
  output logic                    mem_req_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  input  logic                    mem_gnt_i,
  input  logic [WORD_BYTES*8-1:0] mem_rdata_i,
  input  logic                    txd_req_i,
  output logic                    txd_o,
  output logic                    underrun_o
);
  localparam int unsigned FIFO_BYTES = FIFO_WORDS * WORD_BYTES;
  localparam int unsigned CNT_W      = $clog2(FIFO_BYTES + 1);
  localparam int unsigned PTR_W      = $clog2(FIFO_BYTES);
  localparam int unsigned LANE_W     = $clog2(WORD_BYTES + 1);
  localparam int unsigned UNIT_WORDS = (UNIT_BYTES + WORD_BYTES - 1) / WORD_BYTES;
  localparam int unsigned LAST_BYTES = UNIT_BYTES - (UNIT_WORDS - 1) * WORD_BYTES;

  logic                    push, pop, empty;
  logic [LANE_W-1:0]       push_n;
  logic [WORD_BYTES*8-1:0] push_data;
  logic [BYTE_W-1:0]       pop_data;
  logic [CNT_W-1:0]        count;

  ttx_fifo #(
    .BYTES(FIFO_BYTES), .WORD_BYTES(WORD_BYTES),
    .CNT_W(CNT_W), .PTR_W(PTR_W), .LANE_W(LANE_W)
  ) u_fifo (
    .clk_i, .rst_ni,
    .flush_i    (!en_i),
    .push_i     (push),
    .push_n_i   (push_n),
    .push_data_i(push_data),
    .pop_i      (pop),
    .pop_data_o (pop_data),
    .count_o    (count),
    .empty_o    (empty)
  );

  ttx_fetch #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .UNIT_WORDS(UNIT_WORDS),
    .LAST_BYTES(LAST_BYTES), .FIFO_BYTES(FIFO_BYTES), .REFILL_FREE(REFILL_FREE),
    .CNT_W(CNT_W), .LANE_W(LANE_W)
  ) u_fetch (
    .clk_i, .rst_ni, .en_i, .start_addr_i,
    .fifo_count_i(count),
    .mem_req_o, .mem_addr_o, .mem_gnt_i, .mem_rdata_i,
    .push_o     (push),
    .push_n_o   (push_n),
    .push_data_o(push_data)
  );

  ttx_serial u_serial (
    .clk_i, .rst_ni, .en_i,
    .req_i     (txd_req_i),
    .empty_i   (empty),
    .byte_i    (pop_data),
    .pop_o     (pop),
    .data_o    (txd_o),
    .underrun_o(underrun_o)
  );

  assert_flush_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (empty && !underrun_o && !mem_req_o));
endmodule

// File: tb/sim_ttx_fetch_ctrl.sv
`timescale 1ns/1ps
module sim_ttx_fetch_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0, req = 1'b0;
  logic [31:0] start_addr = 32'h1000;
  logic        mem_req, mem_gnt, txd, underrun;
  logic [31:0] mem_addr, mem_rdata;

  int checks = 0, fails = 0, cyc = 0, gnt_mode = 0, grants = 0;
  logic [31:0] exp_addr = 32'h1000, sbase = 32'h1000, stall_addr = '0;
  int pos = 0;
  bit stall_prev = 0, done = 0;

  always #10 clk = ~clk;

  ttx_fetch_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_addr_i(start_addr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt),
    .mem_rdata_i(mem_rdata), .txd_req_i(req), .txd_o(txd), .underrun_o(underrun)
  );

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return 8'((a * 13 + (a >> 8)) ^ 32'hA5);
  endfunction

  always_ff @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    mem_gnt   = mem_req && (gnt_mode == 0 || (gnt_mode == 1 && (cyc % 3) == 0));
    mem_rdata = {mbyte(mem_addr + 3), mbyte(mem_addr + 2), mbyte(mem_addr + 1), mbyte(mem_addr)};
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // grant monitor: address sequence (R3) and stall holding (R8)
  always @(negedge clk) if (rst_n) begin
    if (stall_prev && mem_req) check(mem_addr == stall_addr, "R8 addr held in stall", mem_addr, stall_addr);
    if (mem_req && mem_gnt) begin
      check(mem_addr == exp_addr, "R3 word address", mem_addr, exp_addr);
      exp_addr = exp_addr + 4;
      grants++;
    end
    stall_prev = mem_req && !mem_gnt;
    stall_addr = mem_addr;
  end

  // R4/R5: pull n bytes, MSB first, compare with block layout
  task automatic read_bytes(input int n);
    @(negedge clk);
    req = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = '0;
      logic [7:0] e;
      for (int k = 0; k < 8; k++) begin
        @(posedge clk);
        @(negedge clk);
        b = {b[6:0], txd};
      end
      e = mbyte(sbase + 32'(48 * (pos / 46) + pos % 46));
      check(b == e, "R4 R5 stream byte", {24'h0, b}, {24'h0, e});
      pos++;
    end
    req = 1'b0;
  endtask

  task automatic restart(input logic [31:0] a, input int mode);
    @(negedge clk);
    en = 1'b0;
    start_addr = a;
    gnt_mode = mode;
    @(negedge clk);
    @(negedge clk);
    check(!underrun && !mem_req, "R7 cleared while disabled", {30'h0, underrun, mem_req}, 32'h0);
    exp_addr = a & ~32'h3;
    sbase = a & ~32'h3;
    pos = 0;
    grants = 0;
    en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!mem_req && !txd && !underrun, "R1 reset state", {29'h0, mem_req, txd, underrun}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;
    repeat (40) @(negedge clk);
    check(grants == 12, "R3 words per block", 32'(grants), 32'd12);
    check(!mem_req, "R2 no fetch with 46 held", {31'h0, mem_req}, 32'h0);

    read_bytes(29);
    repeat (20) @(negedge clk);
    check(grants == 12, "R2 no fetch with 17 held", 32'(grants), 32'd12);
    read_bytes(1);
    repeat (20) @(negedge clk);
    check(grants == 24, "R2 fetch with 16 held", 32'(grants), 32'd24);

    repeat (5) begin
      @(negedge clk);
      check(!txd, "R5 line low without request", {31'h0, txd}, 32'h0);
    end

    gnt_mode = 1;
    read_bytes(150);

    // flush with grant withheld: FIFO must be empty -> underrun (R6, R7)
    restart(32'h2000, 2);
    @(negedge clk);
    check(!underrun, "R6 no underrun before request", {31'h0, underrun}, 32'h0);
    req = 1'b1;
    repeat (3) @(negedge clk);
    check(underrun, "R6 R7 underrun after flush", {31'h0, underrun}, 32'h1);
    check(!txd, "R6 line low on underrun", {31'h0, txd}, 32'h0);
    req = 1'b0;
    repeat (4) @(negedge clk);
    check(underrun, "R6 flag sticky", {31'h0, underrun}, 32'h1);

    // reload with an unaligned address; stream restarts there (R3, R7)
    restart(32'h3002, 0);
    repeat (30) @(negedge clk);
    read_bytes(60);
    check(!underrun, "R7 no underrun after reload", {31'h0, underrun}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule